// File: doc/BRIEF.md
# Sampled Shadow-Tag Sharing Classifier

This block sits beside one core's port into a shared last-level cache. For a small group of sampled sets it keeps a shadow tag directory. The directory behaves like a private cache of the full shared size with the same number of ways. Each request from the core names a set, a tag, the shared cache's hit or miss outcome and whether the access is a load. On every sampled request the block compares the shadow outcome with the shared outcome. A shared miss that the private copy would have hit is counted as interference from another thread. A shared hit that the private copy would have missed is counted as data that another thread brought in.

Beside these two counts the block keeps several raw counts that software combines. They are:
- total requests;
- sampled requests, whose ratio to the total gives the scale-up factor;
- load misses in the shared cache;
- cycles the core is stalled on such misses.

The stall and miss counts together give the average miss penalty. All counters saturate and are read through a small select-and-read port. One strobe clears them all together.

Top module: `shadow_share_classifier`

## Requirements
- R1: After reset every counter reads 0. A cycle with `clr_i` high leaves every counter at 0 on the next cycle, even when a request or stall is present in that same cycle.
- R2: The total counter (select 0) rises by one for every cycle with `req_valid_i` high.
- R3: A request is sampled when bits `[SET_IDX_W-1:SAMPLE_LOG2]` of `req_set_i` are all zero. The sampled counter (select 1) rises by one for each sampled request.
- R4: The inter-thread-miss counter (select 2) rises by one for each sampled request that has `req_shared_hit_i`=0 and whose tag is present in the shadow set before the access.
- R5: The inter-thread-hit counter (select 3) rises by one for each sampled request that has `req_shared_hit_i`=1 and whose tag is absent from the shadow set before the access.
- R6: The shadow set is addressed by `req_set_i[SAMPLE_LOG2-1:0]` and holds `WAYS` tags under true LRU, filling empty ways first. Every sampled request, whatever the shared outcome, makes its tag the most recently used entry. Requests that are not sampled leave the shadow state unchanged.
- R7: The load-miss counter (select 4) rises by one for each request with `req_load_i`=1 and `req_shared_hit_i`=0, in any set.
- R8: The stall counter (select 5) rises by one for every cycle with `stall_i` high.
- R9: A counter at all ones stays at all ones instead of wrapping. No counter ever decreases except through `clr_i`.
- R10: `rd_data_o` combinationally shows the counter chosen by `rd_sel_i`. Selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of all counters |
| req_valid_i | input | 1 | A request from this core is present |
| req_set_i | input | SET_IDX_W | Shared-cache set index |
| req_tag_i | input | TAG_W | Address tag |
| req_shared_hit_i | input | 1 | Shared cache hit (1) or miss (0) |
| req_load_i | input | 1 | Access is a load (1) or a store (0) |
| stall_i | input | 1 | Core is stalled on a last-level load miss this cycle |
| rd_sel_i | input | 3 | Counter select |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The properties assume three things about the inputs:
- the request stream comes from this core only;
- `req_shared_hit_i` is meaningful only while `req_valid_i` is high;
- `stall_i` is an independent per-cycle level that needs no relation to the requests.

A per-counter rule bounds what may move each count. It holds whatever the mix of hit flags and access types.

The stimulus sweeps every set of a small configuration: sixteen sets, four of them sampled, two ways and four tags. Collisions and evictions therefore happen often. Tags and flags come from a deterministic generator and are always driven to known values. Clears are inserted both alone and on top of live requests. Counters are six bits wide, so saturation is reached within the run.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   localparam int NUM_CNT   = 6;
   localparam int SEL_W     = 3;
   localparam int CI_TOTAL  = 0;
   localparam int CI_SAMPLE = 1;
   localparam int CI_XMISS  = 2;
   localparam int CI_XHIT   = 3;
   localparam int CI_LMISS  = 4;
   localparam int CI_STALL  = 5;
endpackage

// File: rtl/ssc_sat_cnt.sv
module ssc_sat_cnt #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] MAXV = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (clr)              q <= '0;
      else if (inc && q != MAXV) q <= q + 1'b1;
   end
endmodule

// File: rtl/ssc_shadow_dir.sv
module ssc_shadow_dir #(
   parameter int SETS_LOG2 = 5,
   parameter int WAYS      = 4,
   parameter int TAG_W     = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [SETS_LOG2-1:0] acc_idx,
   input  logic [TAG_W-1:0]     acc_tag,
   output logic                 hit
);
   localparam int SETS  = 1 << SETS_LOG2;
   localparam int AGE_W = $clog2(WAYS);
   localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic             vld_q [SETS][WAYS];
   logic [AGE_W-1:0] age_q [SETS][WAYS];

   logic [WAYS-1:0]  hit_vec;
   logic [AGE_W-1:0] hit_way, vic_way, use_way;
   logic             empty_found;

   always_comb begin
      for (int w = 0; w < WAYS; w++)
         hit_vec[w] = vld_q[acc_idx][w] && (tag_q[acc_idx][w] == acc_tag);
   end
   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = AGE_W'(w);
   end

   // empty ways first, lowest index wins; otherwise the oldest way
   always_comb begin
      vic_way     = '0;
      empty_found = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!empty_found && !vld_q[acc_idx][w]) begin
            vic_way     = AGE_W'(w);
            empty_found = 1'b1;
         end
      end
      if (!empty_found) begin
         for (int w = 0; w < WAYS; w++)
            if (age_q[acc_idx][w] == OLDEST) vic_way = AGE_W'(w);
      end
   end

   assign use_way = hit ? hit_way : vic_way;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w] <= '0;
               vld_q[s][w] <= 1'b0;
               age_q[s][w] <= AGE_W'(w);
            end
         end
      end else if (acc_valid) begin
         for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == use_way)
               age_q[acc_idx][w] <= '0;
            else if (age_q[acc_idx][w] < age_q[acc_idx][use_way])
               age_q[acc_idx][w] <= age_q[acc_idx][w] + 1'b1;
         end
         if (!hit) begin
            tag_q[acc_idx][use_way] <= acc_tag;
            vld_q[acc_idx][use_way] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/shadow_share_classifier.sv
module shadow_share_classifier
   import ssc_pkg::*;
#(
   parameter int SET_IDX_W   = 11,
   parameter int SAMPLE_LOG2 = 5,
   parameter int WAYS        = 4,
   parameter int TAG_W       = 20,
   parameter int CNT_W       = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 req_valid_i,
   input  logic [SET_IDX_W-1:0] req_set_i,
   input  logic [TAG_W-1:0]     req_tag_i,
   input  logic                 req_shared_hit_i,
   input  logic                 req_load_i,
   input  logic                 stall_i,
   input  logic [2:0]           rd_sel_i,
   output logic [CNT_W-1:0]     rd_data_o
);
   localparam int FLAT_W = NUM_CNT * CNT_W;

   if (SAMPLE_LOG2 < 1 || SAMPLE_LOG2 > SET_IDX_W) begin : g_bad_sample
      $error("SAMPLE_LOG2 must lie in 1..SET_IDX_W");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic sampled;
   if (SAMPLE_LOG2 == SET_IDX_W) begin : g_all_sampled
      assign sampled = 1'b1;
   end else begin : g_part_sampled
      assign sampled = (req_set_i[SET_IDX_W-1:SAMPLE_LOG2] == '0);
   end

   logic samp_acc, shadow_hit;
   assign samp_acc = req_valid_i && sampled;

   ssc_shadow_dir #(
      .SETS_LOG2(SAMPLE_LOG2),
      .WAYS     (WAYS),
      .TAG_W    (TAG_W)
   ) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_valid(samp_acc),
      .acc_idx  (req_set_i[SAMPLE_LOG2-1:0]),
      .acc_tag  (req_tag_i),
      .hit      (shadow_hit)
   );

   logic [NUM_CNT-1:0] inc;
   always_comb begin
      inc            = '0;
      inc[CI_TOTAL]  = req_valid_i;
      inc[CI_SAMPLE] = samp_acc;
      inc[CI_XMISS]  = samp_acc && !req_shared_hit_i && shadow_hit;
      inc[CI_XHIT]   = samp_acc && req_shared_hit_i && !shadow_hit;
      inc[CI_LMISS]  = req_valid_i && req_load_i && !req_shared_hit_i;
      inc[CI_STALL]  = stall_i;
   end

   logic [FLAT_W-1:0] cnt_flat;
   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      ssc_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (clr_i),
         .inc  (inc[i]),
         .q    (cnt_flat[i*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM_CNT; i++)
         if (rd_sel_i == SEL_W'(i)) rd_data_o = cnt_flat[i*CNT_W +: CNT_W];
   end
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk
   import ssc_pkg::*;
#(
   parameter int SET_IDX_W   = 11,
   parameter int SAMPLE_LOG2 = 5,
   parameter int CNT_W       = 48
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       clr_i,
   input logic                       req_valid_i,
   input logic [SET_IDX_W-1:0]       req_set_i,
   input logic                       req_shared_hit_i,
   input logic                       req_load_i,
   input logic                       stall_i,
   input logic [2:0]                 rd_sel_i,
   input logic [CNT_W-1:0]           rd_data_o,
   input logic [NUM_CNT*CNT_W-1:0]   cnt_flat
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] c_total, c_samp, c_xmiss, c_xhit, c_lmiss, c_stall;
   assign c_total = cnt_flat[CI_TOTAL*CNT_W  +: CNT_W];
   assign c_samp  = cnt_flat[CI_SAMPLE*CNT_W +: CNT_W];
   assign c_xmiss = cnt_flat[CI_XMISS*CNT_W  +: CNT_W];
   assign c_xhit  = cnt_flat[CI_XHIT*CNT_W   +: CNT_W];
   assign c_lmiss = cnt_flat[CI_LMISS*CNT_W  +: CNT_W];
   assign c_stall = cnt_flat[CI_STALL*CNT_W  +: CNT_W];

   logic unsampled;
   assign unsampled = (SAMPLE_LOG2 < SET_IDX_W) && ((req_set_i >> SAMPLE_LOG2) != '0);

   // R1
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_flat == '0));

   // R2
   total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !clr_i && c_total != MAXV) |=> (c_total == $past(c_total) + 1'b1));

   // R3
   unsampled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && (!req_valid_i || unsampled)) |=> $stable(c_samp));

   // R4
   xmiss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(req_valid_i && !req_shared_hit_i && !unsampled)) |=> $stable(c_xmiss));

   // R5
   xhit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(req_valid_i && req_shared_hit_i && !unsampled)) |=> $stable(c_xhit));

   // R7
   lmiss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(req_valid_i && req_load_i && !req_shared_hit_i)) |=> $stable(c_lmiss));

   // R8
   stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && stall_i && c_stall != MAXV) |=> (c_stall == $past(c_stall) + 1'b1));

   // R9
   for (genvar i = 0; i < NUM_CNT; i++) begin : g_mono
      no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_i |=> (cnt_flat[i*CNT_W +: CNT_W] >= $past(cnt_flat[i*CNT_W +: CNT_W])));
   end

   // R10
   always_comb begin
      if (rst_n && rd_sel_i >= SEL_W'(NUM_CNT))
         unused_sel_chk: assert (rd_data_o == '0);
   end
endmodule

bind shadow_share_classifier ssc_chk #(
   .SET_IDX_W  (SET_IDX_W),
   .SAMPLE_LOG2(SAMPLE_LOG2),
   .CNT_W      (CNT_W)
) i_ssc_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .clr_i           (clr_i),
   .req_valid_i     (req_valid_i),
   .req_set_i       (req_set_i),
   .req_shared_hit_i(req_shared_hit_i),
   .req_load_i      (req_load_i),
   .stall_i         (stall_i),
   .rd_sel_i        (rd_sel_i),
   .rd_data_o       (rd_data_o),
   .cnt_flat        (cnt_flat)
);

// File: tb/test_shadow_share_classifier.sv
module test_shadow_share_classifier;
   localparam int CLK_P = 10;
   localparam int SIW   = 4;
   localparam int SLOG  = 2;
   localparam int NW    = 2;
   localparam int TW    = 4;
   localparam int CW    = 6;
   localparam int NSS   = 1 << SLOG;
   localparam int CMAX  = (1 << CW) - 1;

   logic          clk = 0, rst_n = 0, clr = 0, valid = 0, shit = 0, load = 0, stall = 0;
   logic [SIW-1:0] set = '0;
   logic [TW-1:0]  tag = '0;
   logic [2:0]     sel = '0;
   logic [CW-1:0]  rdata;

   shadow_share_classifier #(.SET_IDX_W(SIW), .SAMPLE_LOG2(SLOG), .WAYS(NW),
      .TAG_W(TW), .CNT_W(CW)) i_shadow_share_classifier (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_valid_i(valid), .req_set_i(set),
      .req_tag_i(tag), .req_shared_hit_i(shit), .req_load_i(load), .stall_i(stall),
      .rd_sel_i(sel), .rd_data_o(rdata));

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   int exp_c [8];
   int m_tag [NSS][NW];   // index 0 = most recent
   int m_n   [NSS];
   int xs = 32'h1234_5678;
   bit done = 0;

   function automatic int nxt();
      xs ^= xs << 13; xs ^= xs >>> 17; xs ^= xs << 5;
      return xs & 32'h7fff_ffff;
   endfunction

   function automatic void bump(int i);
      if (exp_c[i] < CMAX) exp_c[i]++;
   endfunction

   // reference shadow: returns 1 when tag was present before the access
   function automatic bit mdl_access(int s, int t);
      int pos = -1;
      for (int k = 0; k < m_n[s]; k++) if (m_tag[s][k] == t) pos = k;
      if (pos < 0) begin
         if (m_n[s] < NW) m_n[s]++;
         pos = m_n[s] - 1;
      end
      for (int k = pos; k > 0; k--) m_tag[s][k] = m_tag[s][k-1];
      m_tag[s][0] = t;
      return (pos >= 0) && (m_tag[s][0] == t) && 1'b1;
   endfunction

   task automatic step(bit v, int s, int t, bit h, bit ld, bit st, bit c);
      bit was_hit;
      @(negedge clk);
      valid = v; set = SIW'(s); tag = TW'(t); shit = h; load = ld; stall = st; clr = c;
      if (v && s < NSS) begin
         was_hit = 0;
         for (int k = 0; k < m_n[s]; k++) if (m_tag[s][k] == t) was_hit = 1;
         void'(mdl_access(s, t));
      end else was_hit = 0;
      if (c) begin
         for (int i = 0; i < 8; i++) exp_c[i] = 0;
      end else begin
         if (v) bump(0);
         if (v && s < NSS) bump(1);
         if (v && s < NSS && !h && was_hit) bump(2);
         if (v && s < NSS && h && !was_hit) bump(3);
         if (v && ld && !h) bump(4);
         if (st) bump(5);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      valid = 0; shit = 0; load = 0; stall = 0; clr = 0;
   endtask

   function automatic string req_of(int i);
      case (i)
         0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
         4: return "R7"; 5: return "R8"; default: return "R10";
      endcase
   endfunction

   task automatic check_all(string phase, string extra);
      idle();
      for (int i = 0; i < 8; i++) begin
         sel = 3'(i);
         #1;
         n_chk++;
         if (int'(rdata) !== exp_c[i]) begin
            n_bad++;
            $display("FAIL %s %s%s sel=%0d actual=%0d expected=%0d",
                     req_of(i), extra, phase, i, rdata, exp_c[i]);
         end
      end
   endtask

   task automatic rand_run(int n);
      for (int k = 0; k < n; k++) begin
         int r = nxt();
         step(r[0] | r[1], (r >> 2) & 15, (r >> 6) & 3, r[8], r[9], r[10] & r[11],
              ((r >> 12) & 63) == 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) exp_c[i] = 0;
      for (int s = 0; s < NSS; s++) m_n[s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      check_all("reset", "R1 ");

      // R6 directed: fill, reuse, eviction, unsampled set untouched
      step(1, 1, 0, 0, 1, 0, 0);
      step(1, 1, 1, 0, 1, 0, 0);
      step(1, 1, 0, 0, 1, 1, 0);   // shadow hit -> cross miss
      step(1, 1, 2, 0, 0, 0, 0);   // evicts tag 1
      step(1, 9, 1, 0, 0, 0, 0);   // unsampled, same low bits
      step(1, 1, 1, 1, 0, 0, 0);   // shadow miss, shared hit -> cross hit
      step(1, 1, 2, 0, 0, 1, 0);   // still present -> cross miss
      idle();
      sel = 3'd2; #1; n_chk++;
      if (rdata !== 6'd2) begin
         n_bad++; $display("FAIL R6 R4 directed actual=%0d expected=2", rdata);
      end
      sel = 3'd3; #1; n_chk++;
      if (rdata !== 6'd1) begin
         n_bad++; $display("FAIL R6 R5 directed actual=%0d expected=1", rdata);
      end
      check_all("directed", "R6 ");

      // R1 clear on top of a live request and stall
      step(1, 0, 3, 1, 1, 1, 1);
      check_all("clear", "R1 ");

      // sweep every set x tag x hit x load
      for (int s = 0; s < 16; s++)
         for (int t = 0; t < 4; t++)
            for (int hl = 0; hl < 4; hl++)
               step((s + t + hl) % 5 != 0, s, t, hl[0], hl[1], hl == 3, 0);
      check_all("sweep", "R9 ");
      step(0, 0, 0, 0, 0, 0, 1);
      check_all("clear2", "R1 ");

      rand_run(40);
      check_all("rand40", "");
      step(0, 0, 0, 0, 0, 0, 1);
      rand_run(25);
      check_all("rand25", "");
      rand_run(600);
      check_all("rand600", "R9 ");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule